// File: doc/BRIEF.md
# Page Program Load Buffer with Inter-Load Timeout

This block gathers the word writes that make up one page program operation and then hands the finished page to a program engine in a single pass. A page is 128 words and starts on a 128-word boundary. The upper address bits name the page and the low seven bits name the word inside it. The buffer starts out holding the erased value, all ones. Any word the host never writes keeps that value and is programmed as all ones.

An external command decoder opens a load window with a one-cycle `arm` pulse. The host then performs write strobes. A strobe is active while both `ce_n` and `we_n` are low. The address is taken in the first cycle of the strobe. The data is taken in the first cycle in which the strobe is seen released. The window has no explicit close command. It closes when no new strobe starts within `TIMEOUT_CYCLES` clock cycles after the end of the previous load.

The whole page then streams out on the commit port, one word per cycle, in ascending order. While this happens the block reports busy, and each streamed word is put back to all ones, so the next window begins with an erased buffer.

Top module: `page_load_buffer`

## Requirements
- R1: After reset, `busy`, `pgm_valid` and `page_err` are 0 and every buffer word holds all ones.
- R2: Strobes made while no window is open (before an `arm` pulse) write nothing: that word still streams out as all ones.
- R3: The address is sampled in the first cycle in which `ce_n` and `we_n` are both low, so later address changes in the same strobe have no effect. The data is sampled in the first cycle in which either signal is seen high again, so earlier data values in the same strobe have no effect.
- R4: The first load of a window fixes the page as `addr[20:7]`. Every word is written to offset `addr[6:0]` of that page.
- R5: A load whose `addr[20:7]` differs from the fixed page is discarded and sets `page_err`. `page_err` stays set until the next `arm` pulse clears it.
- R6: If no strobe is active, `busy` rises exactly `TIMEOUT_CYCLES` clock edges after the edge that processed the end of the most recent load.
- R7: A commit asserts `pgm_valid` and `busy` for exactly 128 consecutive cycles. During these cycles `pgm_addr` is `{page, offset}` with offset 0 to 127 in ascending order, and `pgm_data` is the last value loaded to that offset, or all ones if the offset was never loaded.
- R8: While `busy` is high, strobes and `arm` are ignored. After a commit the buffer holds all ones again.
- R9: A later load to an offset already loaded in the same window replaces the earlier value.
- R10: The timeout counter pauses while a strobe is active, so a strobe longer than `TIMEOUT_CYCLES` does not start a commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle pulse that opens a load window when the block is idle |
| ce_n | input | 1 | Chip enable, active low, synchronous to `clk` |
| we_n | input | 1 | Write enable, active low, synchronous to `clk` |
| addr | input | 21 | Word address: page in [20:7], offset in [6:0] |
| din | input | 16 | Load data |
| busy | output | 1 | High while the page is streamed to the program engine |
| page_err | output | 1 | Sticky flag: a load targeted a different page |
| pgm_valid | output | 1 | Commit word valid |
| pgm_addr | output | 21 | Commit word address `{page, offset}` |
| pgm_data | output | 16 | Commit word data |

## Verification
Embedded properties check the shape of every commit on every cycle:
- the first offset is zero;
- offsets step up by one;
- the page field stays still;
- a commit only begins after a full idle gap;
- the error flag only rises from a strobe end that targets the wrong page.

Only the bench's scenarios can show the following:
- that words land at the right offsets with the right data;
- that mid-strobe address and data changes are ignored;
- that idle-time and busy-time strobes leave no trace;
- that the buffer comes back erased for the next window.

// File: rtl/page_load_buffer.sv
module page_load_buffer #(
  parameter int ADDR_W         = 21,
  parameter int DATA_W         = 16,
  parameter int PAGE_WORDS     = 128,
  parameter int TIMEOUT_CYCLES = 1500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              page_err,
  output logic              pgm_valid,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [DATA_W-1:0] pgm_data
);
  localparam int OFF_W = $clog2(PAGE_WORDS);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  st_t               state;
  logic [DATA_W-1:0] mem [PAGE_WORDS];
  logic              strb_q, have_pg, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PG_W-1:0]   page_q;
  logic [CNT_W-1:0]  cnt;
  logic [OFF_W-1:0]  idx;

  wire strobe   = ~ce_n & ~we_n;
  wire s_start  = strobe & ~strb_q;
  wire s_end    = ~strobe & strb_q;
  wire same_pg  = page_q == addr_q[ADDR_W-1:OFF_W];
  wire loading  = state == S_LOAD;
  wire accept   = loading && s_end && (!have_pg || same_pg);
  wire mismatch = loading && s_end && have_pg && !same_pg;
  wire expire   = loading && have_pg && !strobe && !s_end &&
                  cnt == CNT_W'(TIMEOUT_CYCLES - 1);

  assign busy      = state == S_PROG;
  assign pgm_valid = busy;
  assign pgm_addr  = {page_q, idx};
  assign pgm_data  = mem[idx];
  assign page_err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_WORDS; i++) mem[i] <= '1;
    end else if (busy) begin
      mem[idx] <= '1;
    end else if (accept) begin
      mem[addr_q[OFF_W-1:0]] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      strb_q  <= 1'b0;
      addr_q  <= '0;
      page_q  <= '0;
      have_pg <= 1'b0;
      err_q   <= 1'b0;
      cnt     <= '0;
      idx     <= '0;
    end else begin
      strb_q <= strobe;
      if (s_start) addr_q <= addr;
      case (state)
        S_IDLE: if (arm) begin
          state   <= S_LOAD;
          have_pg <= 1'b0;
          err_q   <= 1'b0;
          cnt     <= '0;
        end
        S_LOAD: begin
          if (accept) begin
            if (!have_pg) page_q <= addr_q[ADDR_W-1:OFF_W];
            have_pg <= 1'b1;
            cnt     <= '0;
          end else if (mismatch) begin
            err_q <= 1'b1;
            cnt   <= '0;
          end else if (expire) begin
            state <= S_PROG;
            idx   <= '0;
          end else if (have_pg && !strobe) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_PROG: begin
          idx <= idx + OFF_W'(1);
          if (idx == OFF_W'(PAGE_WORDS - 1)) begin
            state   <= S_IDLE;
            have_pg <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_first_word_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> pgm_addr[OFF_W-1:0] == '0);

  p_ascending_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> pgm_addr[OFF_W-1:0] == $past(pgm_addr[OFF_W-1:0]) + OFF_W'(1));

  p_page_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(pgm_addr[ADDR_W-1:OFF_W]));

  p_commit_after_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cnt) == CNT_W'(TIMEOUT_CYCLES - 1) && !$past(strobe));

  p_err_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_err) |-> $past(s_end) && $past(have_pg) && $past(state) == S_LOAD);

  p_busy_blocks_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !$rose(page_err));
endmodule

// File: tb/tb_page_load_buffer.sv
module tb_page_load_buffer;
  localparam int T = 32;

  logic        clk = 1'b0, rst_n = 1'b0, arm = 1'b0, ce_n = 1'b1, we_n = 1'b1;
  logic [20:0] addr = '0;
  logic [15:0] din = '0;
  logic        busy, page_err, pgm_valid;
  logic [20:0] pgm_addr;
  logic [15:0] pgm_data;

  int checks = 0, errors = 0;
  logic [15:0] exp_mem [128];

  // vector: [31:24] offset, [23:8] data, [7:0] extra hold cycles
  localparam logic [31:0] VEC [8] = '{
    {8'd0,   16'h1111, 8'd2},
    {8'd127, 16'h2222, 8'd3},
    {8'd64,  16'h3333, 8'd1},
    {8'd9,   16'h4444, 8'd2},
    {8'd64,  16'h5555, 8'd2},
    {8'd100, 16'h6666, 8'd45},
    {8'd1,   16'h0000, 8'd1},
    {8'd126, 16'hABCD, 8'd2}
  };
  localparam logic [13:0] PG_A = 14'h0A5;
  localparam logic [13:0] PG_B = 14'h001;

  page_load_buffer #(.TIMEOUT_CYCLES(T)) dut (
    .clk, .rst_n, .arm, .ce_n, .we_n, .addr, .din,
    .busy, .page_err, .pgm_valid, .pgm_addr, .pgm_data);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic load(input logic [20:0] a, input logic [15:0] d, input int hold);
    @(negedge clk); addr = a; din = ~d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = ~a;
    repeat (hold) @(negedge clk);
    if (hold > T) chk(busy == 1'b0, "R10", "busy during long strobe", 32'(busy), 0);
    we_n = 1'b1; din = d;
    @(negedge clk); ce_n = 1'b1; din = 16'h0; addr = '0;
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic wait_commit(output int k);
    k = 1;
    while (!busy && k < T + 20) begin
      @(negedge clk); k++;
    end
  endtask

  task automatic commit_check(input logic [13:0] pg, input bit second);
    string tag;
    for (int i = 0; i < 128; i++) begin
      if (second) tag = "R8";
      else if (i == 0) tag = "R3";
      else if (i == 5) tag = "R2";
      else if (i == 3) tag = "R5";
      else if (i == 64) tag = "R9";
      else if (i == 100) tag = "R10";
      else if (i == 127) tag = "R4";
      else tag = "R7";
      chk(pgm_valid && pgm_addr == {pg, 7'(i)} && pgm_data == exp_mem[i], tag,
          $sformatf("word %0d addr/data", i), {pgm_valid, pgm_addr[14:0], pgm_data},
          {1'b1, pg[7:0], 7'(i), exp_mem[i]});
      if (!second) begin
        if (i == 10) begin ce_n = 1'b0; we_n = 1'b0; addr = {PG_A, 7'd2}; din = 16'h9999; end
        if (i == 13) we_n = 1'b1;
        if (i == 14) ce_n = 1'b1;
        if (i == 20) arm = 1'b1;
        if (i == 21) arm = 1'b0;
      end
      if (i < 127) @(negedge clk);
    end
    @(negedge clk);
    chk(busy == 1'b0 && pgm_valid == 1'b0, "R7", "commit length 128", 32'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k;
    for (int i = 0; i < 128; i++) exp_mem[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk(busy == 0 && pgm_valid == 0 && page_err == 0, "R1", "reset outputs",
        {busy, pgm_valid, page_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pgm_data == 16'hFFFF, "R1", "reset buffer word 0", 32'(pgm_data), 32'hFFFF);

    load({PG_A, 7'd5}, 16'h1234, 1);
    chk(busy == 1'b0, "R2", "idle strobe no commit", 32'(busy), 0);

    pulse_arm();
    for (int v = 0; v < 8; v++) begin
      load({PG_A, VEC[v][30:24]}, VEC[v][23:8], int'(VEC[v][7:0]));
      exp_mem[VEC[v][30:24]] = VEC[v][23:8];
      repeat (3) @(negedge clk);
    end
    chk(page_err == 1'b0, "R5", "no error on matching pages", 32'(page_err), 0);
    load({PG_B, 7'd3}, 16'hDEAD, 1);
    chk(page_err == 1'b1, "R5", "error on other page", 32'(page_err), 1);

    wait_commit(k);
    chk(k == T + 1, "R6", "timeout cycles to busy", k, T + 1);
    commit_check(PG_A, 1'b0);
    for (int i = 0; i < 128; i++) exp_mem[i] = 16'hFFFF;

    load({PG_B, 7'd7}, 16'h7777, 1);
    repeat (T + 5) @(negedge clk);
    chk(busy == 1'b0, "R8", "arm during busy ignored", 32'(busy), 0);
    chk(page_err == 1'b1, "R5", "error sticky until arm", 32'(page_err), 1);

    pulse_arm();
    chk(page_err == 1'b0, "R5", "arm clears error", 32'(page_err), 0);
    load({PG_B, 7'd7}, 16'h7777, 1);
    exp_mem[7] = 16'h7777;
    wait_commit(k);
    chk(k == T + 1, "R6", "second timeout", k, T + 1);
    commit_check(PG_B, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule